// File: doc/BRIEF.md
# Reconfigurable Fabric Logic Cell

This block is one tile of a mesh of identical cells, each wired only to its four nearest neighbours (north, east, south, west). The cell computes a single Boolean output from its neighbour inputs and offers that output to all four neighbours. No application clock is involved: the output follows the inputs combinationally. A 7-bit configuration record picks the logic primitive, how the logical inputs are rotated onto the physical sides, and which neighbour acts as the cell's configuration parent.

The configuration arrives as a serial stream from the parent neighbour. Each neighbour supplies a local configuration clock, a data bit and an apply strobe. The cell listens only to its parent. The serial shifter doubles as a 7-bit delay stage, so its oldest bit leaves toward the children. The parent clock and apply strobe are forwarded beside it. In this way a whole region can be loaded in postorder, with the deepest descendants first. When a newly applied record names a different parent, the choice is first parked in a 3-bit route shadow. The live route moves only on a falling edge of the new parent's clock.

Top module: `fabric_cell`

## Requirements
- R1: While `rst` is high, and after it is released with no clock activity, the record is mode 000, orientation 0 and parent north, the shifter is all zero, the route is north, and `app_y` and `cfg_dat_out` are 0.
- R2: On a rising edge of the parent's configuration clock with the parent's apply strobe low, the shifter takes the parent's data bit at its low end. The bit it held seven rises earlier leaves on `cfg_dat_out`, so records are sent most significant bit first.
- R3: On a falling edge of the parent's configuration clock, the shifter contents become the active record only if the parent's apply strobe is high. A rising edge while the strobe is high shifts nothing.
- R4: Clock, data and apply activity on any neighbour other than the active parent leaves the record, the shifter and the outputs unchanged.
- R5: Record layout is [6:5] orientation, [4:2] mode, [1:0] parent. The modes are 000 constant 0, 001 constant 1, 010 wire (a), 011 multiplexer, 100 inverter (not a), 101 NAND of a and b, 110 port role and 111 reserved. The reserved mode gives 0. The port role drives the parent's configuration data bit onto `app_y`.
- R6: Physical side indices are 0 north, 1 east, 2 south, 3 west. Logical port l (a=0, b=1, sel=2) reads side (l + orientation) mod 4, a clockwise rotation of 90 degrees per step.
- R7: In multiplexer mode, `app_y` equals b when sel is 1 and a when sel is 0.
- R8: Parent codes are 00 north, 01 east, 10 south, 11 west. After an applied record names a different parent, the old parent stays active. The new parent takes over on the next falling edge of its own clock. Rising edges of the new parent's clock before that falling edge shift nothing.
- R9: `cfg_clk_out` and `cfg_apl_out` copy the active parent's clock and apply strobe.
- R10: `app_y` responds to `nbr_in` with no configuration clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Active-high reset of all configuration state |
| nbr_in | input | 4 | Application inputs from N, E, S, W neighbours (bit 0 = N) |
| cfg_clk_in | input | 4 | Local configuration clocks from each neighbour |
| cfg_dat_in | input | 4 | Serial configuration data from each neighbour |
| cfg_apl_in | input | 4 | Apply strobes from each neighbour |
| app_y | output | 1 | Combinational cell output offered to all neighbours |
| cfg_clk_out | output | 1 | Forwarded parent configuration clock |
| cfg_dat_out | output | 1 | Oldest shifter bit, forwarded to children |
| cfg_apl_out | output | 1 | Forwarded parent apply strobe |

## Verification
The assertions assume that a neighbour's data and apply lines never change on the same instant as its clock. They also assume that during a parent handoff the old parent's clock idles low, so that moving the route cannot make a false edge. The stimulus changes exactly one input per step, keeps data and apply steady across every clock edge, and lowers each clock before it moves on. Handoffs are always made with the old parent's clock low.

// File: rtl/fcell_pkg.sv
package fcell_pkg;
  localparam int NDIR   = 4;
  localparam int DIR_W  = $clog2(NDIR);
  localparam int ORI_W  = 2;
  localparam int MODE_W = 3;
  localparam int REC_W  = ORI_W + MODE_W + DIR_W;
  localparam int NLOG   = 3;

  typedef enum logic [MODE_W-1:0] {
    M_ZERO = 3'd0,
    M_ONE  = 3'd1,
    M_WIRE = 3'd2,
    M_MUX  = 3'd3,
    M_INV  = 3'd4,
    M_NAND = 3'd5,
    M_PORT = 3'd6,
    M_RSVD = 3'd7
  } mode_e;

  typedef struct packed {
    logic [ORI_W-1:0] ori;
    mode_e            mode;
    logic [DIR_W-1:0] par;
  } rec_t;
endpackage

// File: rtl/fc_port_rotate.sv
module fc_port_rotate
  import fcell_pkg::*;
#(
  parameter int N_PHYS = NDIR,
  parameter int N_LOG  = NLOG
) (
  input  logic [N_PHYS-1:0]         phys,
  input  logic [$clog2(N_PHYS)-1:0] ori,
  output logic [N_LOG-1:0]          logi
);
  localparam int IW = $clog2(N_PHYS);

  // logical port g reads physical side (g + ori) mod N_PHYS
  for (genvar g = 0; g < N_LOG; g++) begin : g_rot
    logic [IW-1:0] idx;
    assign idx     = IW'(g) + ori;
    assign logi[g] = phys[idx];
  end
endmodule

// File: rtl/fc_prim.sv
module fc_prim
  import fcell_pkg::*;
(
  input  mode_e           mode,
  input  logic [NLOG-1:0] lp,
  input  logic            ingress,
  output logic            y
);
  logic pa, pb, ps;
  assign pa = lp[0];
  assign pb = lp[1];
  assign ps = lp[2];

  always_comb begin
    unique case (mode)
      M_ZERO:  y = 1'b0;
      M_ONE:   y = 1'b1;
      M_WIRE:  y = pa;
      M_MUX:   y = ps ? pb : pa;
      M_INV:   y = ~pa;
      M_NAND:  y = ~(pa & pb);
      M_PORT:  y = ingress;
      default: y = 1'b0;
    endcase
  end
endmodule

// File: rtl/fc_cfg_store.sv
module fc_cfg_store
  import fcell_pkg::*;
(
  input  logic             rst,
  input  logic             sel_clk,
  input  logic             sel_dat,
  input  logic             sel_apl,
  input  logic [DIR_W-1:0] route_q,
  input  logic             ack_q,
  output rec_t             rec_q,
  output logic [REC_W-1:0] shift_q,
  output logic [DIR_W-1:0] shd_dir,
  output logic             shd_tog
);
  // serial intake: rising local edge, only while not applying
  always_ff @(posedge sel_clk or posedge rst) begin
    if (rst)           shift_q <= '0;
    else if (!sel_apl) shift_q <= {shift_q[REC_W-2:0], sel_dat};
  end

  // commit: falling local edge with apply high; park new parent in shadow
  always_ff @(negedge sel_clk or posedge rst) begin
    if (rst) begin
      rec_q   <= rec_t'('0);
      shd_dir <= '0;
      shd_tog <= 1'b0;
    end else if (sel_apl) begin
      rec_q   <= rec_t'(shift_q);
      shd_dir <= shift_q[DIR_W-1:0];
      shd_tog <= ack_q ^ (shift_q[DIR_W-1:0] != route_q);
    end
  end

  a_r2_shift_in: assert property (@(posedge sel_clk) disable iff (rst)
    !sel_apl |=> (shift_q[0] == $past(sel_dat)));

  a_r3_hold_without_apply: assert property (@(negedge sel_clk) disable iff (rst)
    !sel_apl |=> $stable(rec_q));

  a_r8_shadow_matches_record: assert property (@(negedge sel_clk) disable iff (rst)
    sel_apl |=> (shd_dir == rec_q.par));
endmodule

// File: rtl/fc_route.sv
module fc_route
  import fcell_pkg::*;
(
  input  logic             rst,
  input  logic             shd_clk,
  input  logic [DIR_W-1:0] shd_dir,
  input  logic             shd_tog,
  output logic [DIR_W-1:0] route_q,
  output logic             ack_q
);
  // adopt parked parent on a falling edge of that parent's own clock
  always_ff @(negedge shd_clk or posedge rst) begin
    if (rst) begin
      route_q <= '0;
      ack_q   <= 1'b0;
    end else if (shd_tog != ack_q) begin
      route_q <= shd_dir;
      ack_q   <= shd_tog;
    end
  end

  a_r8_adopt_new_parent: assert property (@(negedge shd_clk) disable iff (rst)
    (shd_tog != ack_q) |=> (route_q == $past(shd_dir)));

  a_r8_route_holds_idle: assert property (@(negedge shd_clk) disable iff (rst)
    (shd_tog == ack_q) |=> $stable(route_q));
endmodule

// File: rtl/fabric_cell.sv
module fabric_cell
  import fcell_pkg::*;
(
  input  logic            rst,
  input  logic [NDIR-1:0] nbr_in,
  input  logic [NDIR-1:0] cfg_clk_in,
  input  logic [NDIR-1:0] cfg_dat_in,
  input  logic [NDIR-1:0] cfg_apl_in,
  output logic            app_y,
  output logic            cfg_clk_out,
  output logic            cfg_dat_out,
  output logic            cfg_apl_out
);
  rec_t             rec_q;
  logic [REC_W-1:0] shift_q;
  logic [DIR_W-1:0] route_q, shd_dir;
  logic             shd_tog, ack_q;
  logic             sel_clk, sel_dat, sel_apl, shd_clk;
  logic [NLOG-1:0]  lport;

  assign sel_clk = cfg_clk_in[route_q];
  assign sel_dat = cfg_dat_in[route_q];
  assign sel_apl = cfg_apl_in[route_q];
  assign shd_clk = cfg_clk_in[shd_dir];

  fc_cfg_store u_store (
    .rst     (rst),
    .sel_clk (sel_clk),
    .sel_dat (sel_dat),
    .sel_apl (sel_apl),
    .route_q (route_q),
    .ack_q   (ack_q),
    .rec_q   (rec_q),
    .shift_q (shift_q),
    .shd_dir (shd_dir),
    .shd_tog (shd_tog)
  );

  fc_route u_route (
    .rst     (rst),
    .shd_clk (shd_clk),
    .shd_dir (shd_dir),
    .shd_tog (shd_tog),
    .route_q (route_q),
    .ack_q   (ack_q)
  );

  fc_port_rotate #(.N_PHYS(NDIR), .N_LOG(NLOG)) u_rot (
    .phys (nbr_in),
    .ori  (rec_q.ori),
    .logi (lport)
  );

  fc_prim u_prim (
    .mode    (rec_q.mode),
    .lp      (lport),
    .ingress (sel_dat),
    .y       (app_y)
  );

  assign cfg_clk_out = sel_clk;
  assign cfg_apl_out = sel_apl;
  assign cfg_dat_out = shift_q[REC_W-1];

  a_r5_const_zero: assert property (@(negedge sel_clk) disable iff (rst)
    ((rec_q.mode == M_ZERO) || (rec_q.mode == M_RSVD)) |-> !app_y);

  a_r5_const_one: assert property (@(negedge sel_clk) disable iff (rst)
    (rec_q.mode == M_ONE) |-> app_y);
endmodule

// File: tb/fabric_cell_test.sv
module fabric_cell_test;
  localparam int TCLK_PERIOD = 10;
  localparam int WATCHDOG    = 100000;

  logic       tclk = 1'b0;
  logic       rst  = 1'b1;
  logic [3:0] nbr  = '0;
  logic [3:0] cclk = '0;
  logic [3:0] cdat = '0;
  logic [3:0] capl = '0;
  logic       app_y, cfg_clk_out, cfg_dat_out, cfg_apl_out;

  int    n_vec  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  logic [6:0] m_shift = '0;
  logic [6:0] m_rec   = '0;
  int         m_route = 0;
  int         m_shd   = 0;
  bit         m_pend  = 1'b0;
  logic [3:0] p_clk   = '0;

  always #(TCLK_PERIOD/2) tclk = ~tclk;

  fabric_cell uut (
    .rst (rst), .nbr_in (nbr), .cfg_clk_in (cclk), .cfg_dat_in (cdat),
    .cfg_apl_in (capl), .app_y (app_y), .cfg_clk_out (cfg_clk_out),
    .cfg_dat_out (cfg_dat_out), .cfg_apl_out (cfg_apl_out)
  );

  function automatic logic ref_y();
    int   o;
    logic a, b, s;
    o = int'(m_rec[6:5]);
    a = nbr[(0 + o) % 4];
    b = nbr[(1 + o) % 4];
    s = nbr[(2 + o) % 4];
    case (m_rec[4:2])
      3'd0:    return 1'b0;
      3'd1:    return 1'b1;
      3'd2:    return a;
      3'd3:    return s ? b : a;
      3'd4:    return ~a;
      3'd5:    return ~(a & b);
      3'd6:    return cdat[m_route];
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_update();
    int r;
    if (rst) begin
      m_shift = '0; m_rec = '0; m_route = 0; m_shd = 0; m_pend = 1'b0;
    end else begin
      r = m_route;
      if (!p_clk[r] && cclk[r] && !capl[r]) m_shift = {m_shift[5:0], cdat[r]};
      if (p_clk[r] && !cclk[r] && capl[r]) begin
        m_rec  = m_shift;
        m_shd  = int'(m_shift[1:0]);
        m_pend = (m_shd != m_route);
      end else if (m_pend && p_clk[m_shd] && !cclk[m_shd]) begin
        m_route = m_shd;
        m_pend  = 1'b0;
      end
    end
    p_clk = cclk;
  endtask

  task automatic chk(string what, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", cur_req, what, act, exp);
    end
  endtask

  // one step: inputs already changed by caller; model, wait, compare
  task automatic step();
    model_update();
    @(negedge tclk);
    chk("app_y",       app_y,       ref_y());
    chk("cfg_dat_out", cfg_dat_out, m_shift[6]);
    chk("cfg_clk_out", cfg_clk_out, cclk[m_route]);
    chk("cfg_apl_out", cfg_apl_out, capl[m_route]);
    @(posedge tclk);
  endtask

  task automatic sweep();
    for (int v = 0; v < 16; v++) begin
      nbr = 4'(v);
      step();
    end
  endtask

  task automatic send(int d, logic [6:0] rec, bit apply);
    for (int i = 6; i >= 0; i--) begin
      cdat[d] = rec[i]; step();
      cclk[d] = 1'b1;   step();
      cclk[d] = 1'b0;   step();
    end
    cdat[d] = 1'b0; step();
    if (apply) begin
      capl[d] = 1'b1; step();
      cclk[d] = 1'b1; step();
      cclk[d] = 1'b0; step();
      capl[d] = 1'b0; step();
    end
  endtask

  function automatic logic [6:0] mk(int ori, int mode, int par);
    return {2'(ori), 3'(mode), 2'(par)};
  endfunction

  initial begin
    @(posedge tclk);
    cur_req = "R1";
    rst = 1'b1; step(); step();
    rst = 1'b0; step();
    chk("R1 reset app_y", app_y, 1'b0);
    chk("R1 reset cfg_dat_out", cfg_dat_out, 1'b0);

    cur_req = "R10"; sweep();

    cur_req = "R5";
    for (int m = 0; m < 8; m++) begin
      send(0, mk(0, m, 0), 1'b1);
      sweep();
      if (m == 6) begin
        cdat[0] = 1'b1; step();
        cdat[0] = 1'b0; step();
      end
    end

    cur_req = "R6";
    for (int o = 1; o < 4; o++) begin
      send(0, mk(o, 3, 0), 1'b1);
      sweep();
    end
    send(0, mk(2, 5, 0), 1'b1); sweep();

    cur_req = "R7";
    send(0, mk(0, 3, 0), 1'b1); sweep();

    cur_req = "R3";
    send(0, mk(0, 1, 0), 1'b0); sweep();
    cclk[0] = 1'b1; step();
    cclk[0] = 1'b0; step();
    send(0, mk(0, 4, 0), 1'b1); sweep();

    cur_req = "R2";
    send(0, 7'b1011001, 1'b0);
    send(0, 7'b0110110, 1'b0);

    cur_req = "R4";
    for (int d = 1; d < 4; d++) begin
      send(d, mk(0, 1, d), 1'b1);
      sweep();
    end

    cur_req = "R8";
    send(0, mk(0, 2, 1), 1'b1);
    send(0, mk(0, 1, 1), 1'b0);
    cdat[1] = 1'b1; step();
    cclk[1] = 1'b1; step();
    chk("R8 no shift before adoption", cfg_dat_out, m_shift[6]);
    cclk[1] = 1'b0; step();
    cdat[1] = 1'b0; step();
    send(0, mk(0, 0, 0), 1'b1);
    sweep();
    send(1, mk(0, 5, 1), 1'b1);
    sweep();

    cur_req = "R9";
    capl[1] = 1'b1; step();
    cclk[1] = 1'b1; step();
    cclk[1] = 1'b0; step();
    capl[1] = 1'b0; step();
    cclk[3] = 1'b1; step();
    cclk[3] = 1'b0; step();

    cur_req = "R8";
    send(1, mk(1, 3, 3), 1'b1);
    cclk[3] = 1'b1; step();
    cclk[3] = 1'b0; step();
    send(3, mk(3, 6, 3), 1'b1);
    sweep();

    cur_req = "R1";
    rst = 1'b1; step();
    rst = 1'b0; step();
    sweep();

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge tclk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog %s: actual running expected finished", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule